// File: doc/BRIEF.md
# Dual Wiper Serial Register Slave

This block is the digital front end of a two-channel digital potentiometer. It holds one 8-bit code for each wiper and one 8-bit control register. A host reaches all three over a mode-0 serial link made of a clock, an active-low select, a data input and a data output. The serial lines are oversampled in a faster system clock domain, so the host clock must be several system clocks per half period.

Each frame is 16 bits long and is sent most significant bit first. The first byte holds an operation code in bits 15:13 and a register address in bits 12:8. The second byte holds the data. The serial path is a 16-bit shift register. Bits that enter on the data input leave on the data output 16 host clocks later, so several devices can be chained with each output feeding the next input. When select rises, the device executes the frame that is left in its shift register.

A write takes effect when select rises. A read loads the shift register with a tagged response, and that response is shifted out during the next frame. The control register sets the output drive mode (push-pull or open-drain) and an active-low shutdown flag that is shared by both wipers.

Top module: `dpot_spi_ctrl`

## Requirements
- R1: After reset both wiper outputs read 80h, `shutdown_o` is 0 and the control register holds 40h. The data output is not driven.
- R2: A write with op 110b stores the data byte into the register at the frame address: address 00000b selects wiper 0, 00001b selects wiper 1 and 10000b selects the control register. The register changes only when select rises, never while select is still low after the 16th clock.
- R3: A read with op 100b, executed when select rises, loads the shift register with {111b, the 5-bit address, the 8-bit register value}. The next frame shifts out this word, tag byte first.
- R4: Op 011b writes the control register and op 001b reads it, whatever the address bits hold. A control read is tagged with address 10000b. Only control bits 6 and 1 can be stored; every other bit reads 0.
- R5: Control bit 6 is active low. When it is 0, `shutdown_o` is 1 and the stored wiper codes are kept unchanged. Setting it back to 1 clears `shutdown_o`, and the same codes are present.
- R6: Control bit 1 selects the output drive. At 0 (push-pull) the output is driven for the whole of an active frame. At 1 (open-drain) the output is driven, and driven low, only when the bit is 0.
- R7: While select is high the data output is not driven (`sdo_oe_o` is 0).
- R8: A frame that ends with fewer than 16 clocks executes nothing.
- R9: The data output carries the bit that entered 16 clocks earlier, so a frame longer than 16 bits passes its first bits through. Only the last 16 bits are executed.
- R10: A write to an unsupported address has no effect. A read from one returns 00h as data. Op codes 010b, 101b and 111b do nothing.
- R11: After reset the device acts on no frame until it has seen a falling edge on select. If select is already low when reset is released, the clocks of that frame are ignored and the data output stays undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for sdo_o (0 = high impedance) |
| wiper_o | output | N_WIPER*8 | Wiper codes, wiper 0 in the low byte |
| shutdown_o | output | 1 | High while the wipers are in shutdown |

## Verification
The bench builds the block with its defaults: two wipers, 8-bit codes and a 16-bit frame. With these values every decoded address (00000b, 00001b, 10000b) sits next to unused ones that can be probed. A 32-bit frame is enough to show both the pass-through delay and which half gets executed. The host clock half period is six system clocks, which leaves room for the synchronizer latency on each edge. Random frames over all eight op codes are mixed with directed cases: a held select, a truncated frame, open-drain readback through a pull-up, and a reset released while select is low.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int DW      = 8;
  localparam int AW      = 5;
  localparam int OPW     = 3;
  localparam int FRAME_W = OPW + AW + DW;

  localparam logic [AW-1:0]  CTRL_ADDR   = 5'h10;
  localparam logic [DW-1:0]  CTRL_RESET  = 8'h40;
  localparam logic [DW-1:0]  CTRL_MASK   = 8'h42;
  localparam logic [DW-1:0]  WIPER_RESET = 8'h80;
  localparam logic [OPW-1:0] READ_TAG    = 3'b111;
  localparam int             SHDN_BIT    = 6;
  localparam int             OD_BIT      = 1;

  typedef enum logic [OPW-1:0] {
    OP_NOP     = 3'b000,
    OP_CTRL_RD = 3'b001,
    OP_CTRL_WR = 3'b011,
    OP_RD      = 3'b100,
    OP_WR      = 3'b110
  } op_e;
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dpot_shifter.sv
module dpot_shifter
  import dpot_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_s_i,
  input  logic          cs_s_i,
  input  logic          sdi_s_i,
  input  logic          rd_load_i,
  input  logic [FW-1:0] rd_word_i,
  output logic          exec_o,
  output logic [FW-1:0] frame_o,
  output logic          active_o,
  output logic          sdo_bit_o
);
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] FULL = CW'(FW);

  logic          sck_d_q, cs_d_q;
  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic [FW-1:0] sh_q;
  logic          sdo_q;
  logic          sck_rise, sck_fall, cs_fall, cs_rise;

  assign sck_rise = sck_s_i & ~sck_d_q;
  assign sck_fall = ~sck_s_i & sck_d_q;
  assign cs_fall  = ~cs_s_i & cs_d_q;
  assign cs_rise  = cs_s_i & ~cs_d_q;

  // executes only a frame that was armed by a select fall and saw a full count
  assign exec_o = cs_rise & armed_q & (cnt_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      sdo_q   <= 1'b0;
    end else begin
      sck_d_q <= sck_s_i;
      cs_d_q  <= cs_s_i;
      if (cs_fall) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
        sdo_q   <= sh_q[FW-1];
      end else if (cs_rise) begin
        armed_q <= 1'b0;
        if (exec_o && rd_load_i) sh_q <= rd_word_i;
      end else if (armed_q) begin
        if (sck_rise) begin
          sh_q <= {sh_q[FW-2:0], sdi_s_i};
          if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
        end
        if (sck_fall) sdo_q <= sh_q[FW-1];
      end
    end
  end

  assign frame_o   = sh_q;
  assign active_o  = armed_q;
  assign sdo_bit_o = sdo_q;

  // R9
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  // R2
  exec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o);
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !cs_fall) |=> $stable(sh_q));
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
  import dpot_pkg::*;
#(
  parameter int N_WIPER = 2,
  parameter int FW      = FRAME_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  exec_i,
  input  logic [FW-1:0]         frame_i,
  output logic [N_WIPER*DW-1:0] wiper_o,
  output logic                  shutdown_o,
  output logic                  od_o,
  output logic                  rd_load_o,
  output logic [FW-1:0]         rd_word_o
);
  logic [OPW-1:0] op;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  data;
  logic           wr_en, rd_en;
  logic [AW-1:0]  wr_addr, rd_addr;
  logic [DW-1:0]  rd_data;
  logic [DW-1:0]  ctrl_q;
  logic [DW-1:0]  wiper_q [N_WIPER];

  assign op   = frame_i[FW-1 -: OPW];
  assign addr = frame_i[DW +: AW];
  assign data = frame_i[DW-1:0];

  always_comb begin
    wr_en   = 1'b0;
    rd_en   = 1'b0;
    wr_addr = addr;
    rd_addr = addr;
    case (op)
      OP_CTRL_RD: begin rd_en = 1'b1; rd_addr = CTRL_ADDR; end
      OP_CTRL_WR: begin wr_en = 1'b1; wr_addr = CTRL_ADDR; end
      OP_RD:      rd_en = 1'b1;
      OP_WR:      wr_en = 1'b1;
      default: ;
    endcase
  end

  for (genvar g = 0; g < N_WIPER; g++) begin : g_wiper
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 wiper_q[g] <= WIPER_RESET;
      else if (exec_i && wr_en && wr_addr == AW'(g)) wiper_q[g] <= data;
    end
    assign wiper_o[g*DW +: DW] = wiper_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    ctrl_q <= CTRL_RESET;
    else if (exec_i && wr_en && wr_addr == CTRL_ADDR) ctrl_q <= data & CTRL_MASK;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_ADDR) rd_data = ctrl_q;
    for (int i = 0; i < N_WIPER; i++)
      if (rd_addr == AW'(i)) rd_data = wiper_q[i];
  end

  assign rd_load_o  = rd_en;
  assign rd_word_o  = {READ_TAG, rd_addr, rd_data};
  assign shutdown_o = ~ctrl_q[SHDN_BIT];
  assign od_o       = ctrl_q[OD_BIT];

  // R2
  wiper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(wiper_o));
  // R5
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> ($stable(shutdown_o) && $stable(od_o)));
  // R10
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && (op == 3'b010 || op == 3'b101 || op == 3'b111))
      |=> ($stable(wiper_o) && $stable(shutdown_o) && $stable(od_o)));
endmodule

// File: rtl/dpot_spi_ctrl.sv
module dpot_spi_ctrl
  import dpot_pkg::*;
#(
  parameter int N_WIPER     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sck_i,
  input  logic                  cs_ni,
  input  logic                  sdi_i,
  output logic                  sdo_o,
  output logic                  sdo_oe_o,
  output logic [N_WIPER*DW-1:0] wiper_o,
  output logic                  shutdown_o
);
  logic [2:0]         pins_s;
  logic               exec, active, sdo_bit, od, rd_load;
  logic [FRAME_W-1:0] frame, rd_word;

  // select resets low so a select held low through reset never arms a frame
  dpot_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sck_i, cs_ni, sdi_i}),
    .q_o    (pins_s)
  );

  dpot_shifter #(.FW(FRAME_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (pins_s[2]),
    .cs_s_i    (pins_s[1]),
    .sdi_s_i   (pins_s[0]),
    .rd_load_i (rd_load),
    .rd_word_i (rd_word),
    .exec_o    (exec),
    .frame_o   (frame),
    .active_o  (active),
    .sdo_bit_o (sdo_bit)
  );

  dpot_regs #(.N_WIPER(N_WIPER), .FW(FRAME_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exec_i     (exec),
    .frame_i    (frame),
    .wiper_o    (wiper_o),
    .shutdown_o (shutdown_o),
    .od_o       (od),
    .rd_load_o  (rd_load),
    .rd_word_o  (rd_word)
  );

  assign sdo_o    = od ? 1'b0 : sdo_bit;
  assign sdo_oe_o = active & (od ? ~sdo_bit : 1'b1);

  // R7
  cs_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_ni, 1) && $past(cs_ni, 2) && $past(cs_ni, 3) && $past(cs_ni, 4)
     && $past(cs_ni, 5)) |-> !sdo_oe_o);
  // R6
  od_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od && sdo_oe_o) |-> !sdo_o);
endmodule

// File: tb/dpot_spi_ctrl_tb_top.sv
module dpot_spi_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 6;
  localparam int NW = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, shdn;
  logic [NW*8-1:0] wip;
  wire bus = sdo_oe ? sdo : 1'b1;

  int errors = 0, checks = 0;

  logic [7:0]  mw [NW];
  logic [7:0]  mctrl;
  logic [15:0] msh;
  bit          marmed;
  int          nbits;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpot_spi_ctrl #(.N_WIPER(NW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .wiper_o(wip), .shutdown_o(shdn)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] mread(logic [4:0] a);
    if (a == 5'h10) return mctrl;
    if (a < NW) return mw[a];
    return 8'h00;
  endfunction

  task automatic mexec();
    logic [2:0] op = msh[15:13];
    logic [4:0] a  = msh[12:8];
    logic [7:0] d  = msh[7:0];
    case (op)
      3'b001: msh = {3'b111, 5'h10, mctrl};
      3'b011: mctrl = d & 8'h42;
      3'b100: msh = {3'b111, a, mread(a)};
      3'b110: begin
        if (a == 5'h10) mctrl = d & 8'h42;
        else if (a < NW) mw[a] = d;
      end
      default: ;
    endcase
  endtask

  task automatic check_state(string req);
    for (int i = 0; i < NW; i++) chk(req, {24'h0, wip[i*8 +: 8]}, {24'h0, mw[i]});
    chk(req, {31'h0, shdn}, {31'h0, ~mctrl[6]});
  endtask

  task automatic do_reset(logic cs_level);
    cs_n = cs_level; sck = 1'b0; rst_ni = 1'b0;
    wclk(4);
    rst_ni = 1'b1;
    wclk(4);
    for (int i = 0; i < NW; i++) mw[i] = 8'h80;
    mctrl = 8'h40; msh = '0; marmed = 0;
  endtask

  task automatic cs_low();
    cs_n = 1'b0; wclk(HP); marmed = 1; nbits = 0;
  endtask

  task automatic cs_high();
    wclk(HP);
    cs_n = 1'b1;
    if (marmed && nbits >= 16) mexec();
    marmed = 0;
    wclk(2*HP);
    chk("R7", {31'h0, sdo_oe}, 32'h0);
  endtask

  task automatic shift_bits(int n, logic [31:0] tx, output logic [31:0] rx,
                            output logic [31:0] ex);
    rx = '0; ex = '0;
    for (int i = 0; i < n; i++) begin
      logic b = tx[n-1-i];
      sdi = b;
      wclk(HP);
      rx[n-1-i] = bus;
      if (!marmed) begin
        ex[n-1-i] = 1'b1;
        chk("R11", {31'h0, sdo_oe}, 32'h0);
      end else begin
        ex[n-1-i] = msh[15];
        msh = {msh[14:0], b};
        nbits++;
        if (mctrl[1]) chk("R6", {31'h0, sdo_oe & sdo}, 32'h0);
        else          chk("R6", {31'h0, sdo_oe}, 32'h1);
      end
      sck = 1'b1;
      wclk(HP);
      sck = 1'b0;
    end
  endtask

  task automatic frame16(string req, logic [15:0] tx, output logic [15:0] rx);
    logic [31:0] r, e;
    cs_low();
    shift_bits(16, {16'h0, tx}, r, e);
    cs_high();
    chk(req, r, e);
    check_state(req);
    rx = r[15:0];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    logic [31:0] r, e;
    void'($urandom(32'd20240611));
    do_reset(1'b1);

    // R1 reset state
    chk("R1", {16'h0, wip}, 32'h8080);
    chk("R1", {31'h0, shdn}, 32'h0);
    chk("R1", {31'h0, sdo_oe}, 32'h0);

    // R2 write held until select rises
    cs_low();
    shift_bits(16, {16'h0, 16'hC1_3C}, r, e);
    wclk(3*HP);
    chk("R2", {24'h0, wip[15:8]}, 32'h80);
    cs_high();
    chk("R2", {24'h0, wip[15:8]}, 32'h3C);
    frame16("R2", 16'hC0_A5, rx);
    chk("R2", {16'h0, wip}, 32'h3CA5);

    // R3 read returns tagged word in next frame
    frame16("R3", 16'h81_00, rx);
    frame16("R3", 16'h00_00, rx);
    chk("R3", {16'h0, rx}, 32'hE13C);

    // R4 control ops ignore address, unused bits read 0, open-drain readback
    frame16("R4", 16'h75_FF, rx);
    frame16("R4", 16'h2A_00, rx);
    frame16("R4", 16'h00_00, rx);
    chk("R4", {16'h0, rx}, 32'hF042);
    frame16("R6", 16'h80_00, rx);
    frame16("R6", 16'h00_00, rx);
    chk("R6", {16'h0, rx}, 32'hE0A5);
    frame16("R6", 16'hD0_40, rx);

    // R5 shutdown active low keeps codes
    frame16("R5", 16'h60_00, rx);
    chk("R5", {31'h0, shdn}, 32'h1);
    chk("R5", {16'h0, wip}, 32'h3CA5);
    frame16("R5", 16'h60_40, rx);
    chk("R5", {31'h0, shdn}, 32'h0);
    chk("R5", {16'h0, wip}, 32'h3CA5);

    // R8 truncated frame
    cs_low();
    shift_bits(10, {22'h0, 10'b110_00000_11}, r, e);
    cs_high();
    chk("R8", r, e);
    chk("R8", {24'h0, wip[7:0]}, 32'hA5);

    // R9 32-bit pass-through, last half executes
    cs_low();
    shift_bits(32, 32'h9ABC_C0_77, r, e);
    cs_high();
    chk("R9", r, e);
    chk("R9", {16'h0, r[15:0]}, 32'h9ABC);
    chk("R9", {24'h0, wip[7:0]}, 32'h77);

    // R10 unsupported address and op codes
    frame16("R10", 16'hC5_11, rx);
    frame16("R10", 16'h85_00, rx);
    frame16("R10", 16'h00_00, rx);
    chk("R10", {16'h0, rx}, 32'hE500);
    frame16("R10", 16'hE0_12, rx);
    frame16("R10", 16'h40_13, rx);
    frame16("R10", 16'hA1_14, rx);
    chk("R10", {16'h0, wip}, 32'h3C77);

    // random frames against the model
    for (int k = 0; k < 60; k++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      logic [4:0] a;
      case ($urandom_range(0, 3))
        0: a = 5'h00;
        1: a = 5'h01;
        2: a = 5'h10;
        default: a = 5'($urandom);
      endcase
      frame16("R3", {op, a, 8'($urandom)}, rx);
    end

    // R11 reset released with select low
    do_reset(1'b0);
    shift_bits(16, {16'h0, 16'hC0_55}, r, e);
    chk("R11", r, e);
    cs_high();
    chk("R11", {16'h0, wip}, 32'h8080);
    frame16("R11", 16'hC0_55, rx);
    chk("R11", {24'h0, wip[7:0]}, 32'h55);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule